// File: doc/BRIEF.md
# Host-Paced Word DMA Mailbox Engine

This block moves 16-bit words between on-chip memory and an external host through one shared mailbox data port. The host does not poll for status. The engine raises a request line (`dreq`) whenever it can take or supply the next word. The host answers each request with a chip-select plus read or write strobe. The engine drops the request after the strobe is released, then moves on to the next word.

An on-chip processor sets up a transfer over a simple register bus. It writes a 22-bit current (start) byte address and a 22-bit end byte address, each as a low/high register pair. It writes a magic value to a pin-control register to let the request line drive. It then writes a second magic value to a start register, which picks the direction. Inbound transfers treat the end address as the last word written (inclusive). Outbound transfers treat it as one word past the last word read (exclusive). Only one direction runs at a time.

The sequencer has six states:
- `ST_IDLE` waits for a start command.
- `ST_FETCH` issues a memory read. It is used outbound only.
- `ST_LOAD` captures the memory data into the output buffer.
- `ST_REQ` holds the request line high until a matching strobe arrives.
- `ST_STROBE` waits for the strobe to be released.
- `ST_ADV` writes memory when inbound, steps the address and decides whether the transfer is finished.

Transitions:
- `ST_IDLE` goes to `ST_REQ` on an inbound start.
- `ST_IDLE` goes to `ST_FETCH` on an outbound start, or stays in `ST_IDLE` with done set if the outbound range is empty.
- `ST_FETCH` goes to `ST_LOAD`, and `ST_LOAD` goes to `ST_REQ`.
- `ST_REQ` goes to `ST_STROBE` when a matching strobe is seen with the pin enabled.
- `ST_STROBE` goes to `ST_ADV` when the strobe is released.
- `ST_ADV` goes to `ST_IDLE` on the last word. Otherwise it goes to `ST_REQ` (inbound) or `ST_FETCH` (outbound).

Top module: `host_dma_mailbox`

## Requirements
- R1: After reset, `dreq` is low, both address registers read 0, the pin-control register reads 0, and the status register (0xC02A) reads 0.
- R2: The current address is written low half at 0xC02C and bits 21:16 at 0xC02E. The end address is written low half at 0xC030 and bits 21:16 at 0xC032. All four registers read back, and writes to them are ignored while a transfer is running.
- R3: In the two high-half registers only bits 5:0 are stored. Bits 15:6 are ignored on write and read back as zero.
- R4: Writing 0x0007 to 0xC0C0 enables the request pin, and that register then reads 0x0007. Any other value disables it, and the register reads 0. While disabled, `dreq` is low and strobes are not accepted.
- R5: Writing 0x0001 to 0xC02A starts an inbound (host to memory) transfer, and 0x0003 starts an outbound one. Other values have no effect. Reading 0xC02A gives done in bit 0 and busy in bit 1.
- R6: A start write while a transfer is running is ignored, and the running transfer keeps its direction.
- R7: Inbound: `host_din` is sampled in the first cycle `host_cs_n` and `host_wr_n` are both seen low. After release it is written to memory at the current address. The word at the end address is written, so (end-start)/2+1 words move.
- R8: Each completed word advances the 22-bit byte address by 2, carrying from the low half into the high half.
- R9: `dreq` stays high while the strobe is held and falls in the cycle after the strobe release is seen.
- R10: Outbound: the word at the current address is fetched before `dreq` rises, and `host_dout` holds it while `host_rd_n` is low. The transfer stops when the address reaches the end address, so start==end moves no word.
- R11: On completion, done is set and `dreq` stays low. The next accepted start clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| dreq | output | 1 | Word request to host |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_din | input | 16 | Data from host |
| host_dout | output | 16 | Data to host |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 22 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid the cycle after a read request |

## Verification
The inbound path is run over a four-word range with distinct data words. This shows whether the end address is treated as inclusive, and whether the address steps by two. The outbound path is run with preloaded memory and a three-word range. This separates exclusive-end handling and prefetch order from inbound behaviour. A range that crosses the 64 KiB boundary shows whether the carry reaches the high half. An empty outbound range and a one-word inbound range are also run, with the pin toggled off mid-request. Together these separate completion handling from gating of the request pin.

// File: rtl/dma_mbx_pkg.sv
package dma_mbx_pkg;
    localparam int REG_AW = 16;
    localparam int REG_DW = 16;

    localparam logic [REG_AW-1:0] OFS_GO      = 16'hC02A;
    localparam logic [REG_AW-1:0] OFS_CUR_LO  = 16'hC02C;
    localparam logic [REG_AW-1:0] OFS_CUR_HI  = 16'hC02E;
    localparam logic [REG_AW-1:0] OFS_END_LO  = 16'hC030;
    localparam logic [REG_AW-1:0] OFS_END_HI  = 16'hC032;
    localparam logic [REG_AW-1:0] OFS_PIN     = 16'hC0C0;

    localparam logic [REG_DW-1:0] PIN_ON_CODE = 16'h0007;
    localparam logic [REG_DW-1:0] GO_IN_CODE  = 16'h0001;
    localparam logic [REG_DW-1:0] GO_OUT_CODE = 16'h0003;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_REQ,
        ST_STROBE,
        ST_ADV
    } dma_state_e;
endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic              step,
    output logic [ADDR_W-1:0] cur
);
    localparam int HI_W = ADDR_W - DATA_W;
    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(2);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (step) begin
            cur <= cur + WORD_BYTES;
        end else begin
            if (ld_lo) cur[DATA_W-1:0]      <= wdata;
            if (ld_hi) cur[ADDR_W-1:DATA_W] <= wdata[HI_W-1:0];
        end
    end
endmodule

// File: rtl/dma_regs.sv
module dma_regs
    import dma_mbx_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    input  logic              busy,
    input  logic              done,
    input  logic [ADDR_W-1:0] cur,
    output logic              ld_cur_lo,
    output logic              ld_cur_hi,
    output logic [ADDR_W-1:0] end_addr,
    output logic              pin_en,
    output logic              go_in,
    output logic              go_out,
    output logic [REG_DW-1:0] reg_rdata
);
    localparam int HI_W = ADDR_W - REG_DW;

    logic cfg_wr;
    assign cfg_wr    = reg_wr && !busy;
    assign ld_cur_lo = cfg_wr && (reg_addr == OFS_CUR_LO);
    assign ld_cur_hi = cfg_wr && (reg_addr == OFS_CUR_HI);
    assign go_in     = cfg_wr && (reg_addr == OFS_GO) && (reg_wdata == GO_IN_CODE);
    assign go_out    = cfg_wr && (reg_addr == OFS_GO) && (reg_wdata == GO_OUT_CODE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_addr <= '0;
            pin_en   <= 1'b0;
        end else begin
            if (cfg_wr && reg_addr == OFS_END_LO) end_addr[REG_DW-1:0]      <= reg_wdata;
            if (cfg_wr && reg_addr == OFS_END_HI) end_addr[ADDR_W-1:REG_DW] <= reg_wdata[HI_W-1:0];
            if (reg_wr && reg_addr == OFS_PIN)    pin_en <= (reg_wdata == PIN_ON_CODE);
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CUR_LO: reg_rdata = cur[REG_DW-1:0];
            OFS_CUR_HI: reg_rdata[HI_W-1:0] = cur[ADDR_W-1:REG_DW];
            OFS_END_LO: reg_rdata = end_addr[REG_DW-1:0];
            OFS_END_HI: reg_rdata[HI_W-1:0] = end_addr[ADDR_W-1:REG_DW];
            OFS_PIN:    reg_rdata = pin_en ? PIN_ON_CODE : '0;
            OFS_GO:     reg_rdata[1:0] = {busy, done};
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_mbx_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_in,
    input  logic              go_out,
    input  logic              pin_en,
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] end_addr,
    input  logic              host_cs_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [DATA_W-1:0] host_din,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              step,
    output logic              busy,
    output logic              done,
    output logic              dir_out,
    output logic              dreq,
    output logic [DATA_W-1:0] host_dout,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(2);

    dma_state_e        state, state_nx;
    logic [DATA_W-1:0] in_buf, out_buf;
    logic              hit, last_word;

    assign hit       = !host_cs_n && (dir_out ? !host_rd_n : !host_wr_n);
    assign last_word = dir_out ? (cur + WORD_BYTES == end_addr) : (cur == end_addr);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (go_in)                              state_nx = ST_REQ;
                else if (go_out && cur != end_addr)     state_nx = ST_FETCH;
            end
            ST_FETCH:  state_nx = ST_LOAD;
            ST_LOAD:   state_nx = ST_REQ;
            ST_REQ:    if (pin_en && hit) state_nx = ST_STROBE;
            ST_STROBE: if (!hit)          state_nx = ST_ADV;
            ST_ADV: begin
                if (last_word)    state_nx = ST_IDLE;
                else if (dir_out) state_nx = ST_FETCH;
                else              state_nx = ST_REQ;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            dir_out <= 1'b0;
            done    <= 1'b0;
            in_buf  <= '0;
            out_buf <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && (go_in || go_out)) begin
                dir_out <= go_out;
                done    <= go_out && (cur == end_addr);
            end
            if (state == ST_REQ && pin_en && hit) in_buf  <= host_din;
            if (state == ST_LOAD)                 out_buf <= mem_rdata;
            if (state == ST_ADV && last_word)     done    <= 1'b1;
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        dreq      = pin_en && (state == ST_REQ || state == ST_STROBE);
        step      = (state == ST_ADV);
        mem_req   = (state == ST_FETCH) || (state == ST_ADV && !dir_out);
        mem_we    = (state == ST_ADV) && !dir_out;
        mem_addr  = cur;
        mem_wdata = in_buf;
        host_dout = out_buf;
    end
endmodule

// File: rtl/host_dma_mailbox.sv
module host_dma_mailbox
    import dma_mbx_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              dreq,
    input  logic              host_cs_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic              ld_cur_lo, ld_cur_hi, pin_en, go_in, go_out;
    logic              step, busy, done, dir_out;
    logic [ADDR_W-1:0] cur, end_addr;

    dma_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(busy), .done(done), .cur(cur),
        .ld_cur_lo(ld_cur_lo), .ld_cur_hi(ld_cur_hi), .end_addr(end_addr),
        .pin_en(pin_en), .go_in(go_in), .go_out(go_out), .reg_rdata(reg_rdata)
    );

    dma_addr_ctr #(.ADDR_W(ADDR_W), .DATA_W(REG_DW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .ld_lo(ld_cur_lo), .ld_hi(ld_cur_hi),
        .wdata(reg_wdata), .step(step), .cur(cur)
    );

    dma_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .go_in(go_in), .go_out(go_out),
        .pin_en(pin_en), .cur(cur), .end_addr(end_addr),
        .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_din(host_din), .mem_rdata(mem_rdata), .step(step), .busy(busy),
        .done(done), .dir_out(dir_out), .dreq(dreq), .host_dout(host_dout),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );
endmodule

// File: rtl/dma_mbx_chk.sv
module dma_mbx_chk
    import dma_mbx_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dreq,
    input logic              pin_en,
    input logic              done,
    input logic              busy,
    input logic              dir_out,
    input logic              host_cs_n,
    input logic              host_rd_n,
    input logic              host_wr_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] cur,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [REG_DW-1:0] reg_rdata
);
    localparam int HI_W = ADDR_W - REG_DW;

    // R4
    pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dreq |-> pin_en);

    // R9
    dreq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_en && $fell(dreq)) |-> $past(host_cs_n || (dir_out ? host_rd_n : host_wr_n)));

    // R11
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !dreq);

    // R8
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (cur == $past(mem_addr) + ADDR_W'(2)));

    // R3
    hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_CUR_HI || reg_addr == OFS_END_HI) |-> (reg_rdata[REG_DW-1:HI_W] == '0));

    // R6
    busy_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == OFS_GO) |=> $stable(dir_out));
endmodule

bind host_dma_mailbox dma_mbx_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .dreq(dreq), .pin_en(pin_en), .done(done),
    .busy(busy), .dir_out(dir_out), .host_cs_n(host_cs_n),
    .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .cur(cur), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/host_dma_mailbox_test.sv
`timescale 1ns/100ps
module host_dma_mailbox_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        dreq;
    logic        host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1;
    logic [15:0] host_din = '0;
    logic [15:0] host_dout;
    logic        mem_req, mem_we;
    logic [21:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    int vectors = 0;
    int miscompares = 0;
    bit m_pin = 1'b0;
    bit finished = 1'b0;
    logic [15:0] bmem [256];
    logic [15:0] rd;

    always #2.5 clk = ~clk;

    host_dma_mailbox uut (.*);

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) bmem[mem_addr[8:1]] <= mem_wdata;
            else        mem_rdata <= bmem[mem_addr[8:1]];
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-clock model: request line only while the modelled pin is on
    always @(negedge clk) begin
        if (rst_n && !finished) check(!(dreq && !m_pin), "R4 dreq while pin off", dreq, 0);
    end

    task automatic reg_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
        if (a == 16'hC0C0) m_pin = (d == 16'h0007);
    endtask

    task automatic reg_read(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic expect_reg(input logic [15:0] a, input logic [15:0] e, input string tag);
        logic [15:0] v;
        reg_read(a, v);
        check(v === e, tag, v, e);
    endtask

    task automatic wait_dreq(input string tag);
        int n = 0;
        while (dreq !== 1'b1 && n < 60) begin @(negedge clk); n++; end
        check(dreq === 1'b1, tag, dreq, 1);
    endtask

    task automatic host_write(input logic [15:0] d);
        wait_dreq("R7 dreq before write");
        host_cs_n = 1'b0; host_wr_n = 1'b0; host_din = d;
        @(negedge clk);
        @(negedge clk);
        check(dreq === 1'b1, "R9 dreq held during write strobe", dreq, 1);
        host_cs_n = 1'b1; host_wr_n = 1'b1; host_din = 16'hDEAD;
        @(negedge clk);
        check(dreq === 1'b0, "R9 dreq low after write release", dreq, 0);
    endtask

    task automatic host_read(input logic [15:0] e, input string tag);
        wait_dreq("R10 dreq before read");
        host_cs_n = 1'b0; host_rd_n = 1'b0;
        @(negedge clk);
        check(host_dout === e, tag, host_dout, e);
        @(negedge clk);
        check(host_dout === e, "R10 data held while read low", host_dout, e);
        check(dreq === 1'b1, "R9 dreq held during read strobe", dreq, 1);
        host_cs_n = 1'b1; host_rd_n = 1'b1;
        @(negedge clk);
        check(dreq === 1'b0, "R9 dreq low after read release", dreq, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 16'h0000;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(dreq === 1'b0, "R1 dreq after reset", dreq, 0);
        expect_reg(16'hC02A, 16'h0000, "R1 status after reset");
        expect_reg(16'hC0C0, 16'h0000, "R1 pin reg after reset");
        expect_reg(16'hC02C, 16'h0000, "R1 cur lo after reset");
        expect_reg(16'hC032, 16'h0000, "R1 end hi after reset");

        // R3 upper bits dropped
        reg_write(16'hC02E, 16'hFFFF);
        expect_reg(16'hC02E, 16'h003F, "R3 cur hi masked");
        reg_write(16'hC032, 16'hFFC1);
        expect_reg(16'hC032, 16'h0001, "R3 end hi masked");

        // R2 address pairs
        reg_write(16'hC02C, 16'h0100); reg_write(16'hC02E, 16'h0000);
        reg_write(16'hC030, 16'h0106); reg_write(16'hC032, 16'h0000);
        expect_reg(16'hC02C, 16'h0100, "R2 cur lo readback");
        expect_reg(16'hC030, 16'h0106, "R2 end lo readback");

        // R5 invalid start value
        reg_write(16'hC02A, 16'h0002);
        expect_reg(16'hC02A, 16'h0000, "R5 bad start code ignored");

        // R4 pin disabled holds dreq low
        reg_write(16'hC02A, 16'h0001);
        repeat (6) @(negedge clk);
        check(dreq === 1'b0, "R4 dreq low with pin off", dreq, 0);
        expect_reg(16'hC02A, 16'h0002, "R5 busy after inbound start");
        reg_write(16'hC0C0, 16'h0007);
        expect_reg(16'hC0C0, 16'h0007, "R4 pin reg reads 7");
        check(dreq === 1'b1, "R4 dreq rises after enable", dreq, 1);

        // R7 inbound, inclusive end
        host_write(16'hA000);
        // R6 start ignored while busy; R2 address write ignored while busy
        reg_write(16'hC02A, 16'h0003);
        reg_write(16'hC02C, 16'h0500);
        expect_reg(16'hC02C, 16'h0102, "R2 cur lo locked while busy");
        host_write(16'hA001);
        host_write(16'hA002);
        host_write(16'hA003);
        repeat (2) @(negedge clk);
        expect_reg(16'hC02A, 16'h0001, "R11 done after inbound");
        expect_reg(16'hC02C, 16'h0108, "R8 cur advanced by 2 per word");
        check(bmem[8'h80] === 16'hA000, "R7 word0", bmem[8'h80], 16'hA000);
        check(bmem[8'h81] === 16'hA001, "R6 direction kept, word1", bmem[8'h81], 16'hA001);
        check(bmem[8'h83] === 16'hA003, "R7 end word written", bmem[8'h83], 16'hA003);
        repeat (5) @(negedge clk);
        check(dreq === 1'b0, "R11 dreq low after done", dreq, 0);

        // R10 outbound, exclusive end
        bmem[8'h20] = 16'h1111; bmem[8'h21] = 16'h2222;
        bmem[8'h22] = 16'h3333; bmem[8'h23] = 16'h4444;
        reg_write(16'hC02C, 16'h0040);
        reg_write(16'hC030, 16'h0046);
        reg_write(16'hC02A, 16'h0003);
        expect_reg(16'hC02A, 16'h0002, "R11 done cleared by start");
        host_read(16'h1111, "R10 read word0");
        host_read(16'h2222, "R10 read word1");
        host_read(16'h3333, "R10 read word2");
        repeat (4) @(negedge clk);
        check(dreq === 1'b0, "R10 no fourth request", dreq, 0);
        expect_reg(16'hC02A, 16'h0001, "R10 done after outbound");
        expect_reg(16'hC02C, 16'h0046, "R8 cur at end after outbound");

        // R10 empty outbound range
        reg_write(16'hC02C, 16'h0060);
        reg_write(16'hC030, 16'h0060);
        reg_write(16'hC02A, 16'h0003);
        expect_reg(16'hC02A, 16'h0001, "R10 empty range done");
        repeat (3) @(negedge clk);
        check(dreq === 1'b0, "R10 empty range no request", dreq, 0);

        // R8 carry into high half
        reg_write(16'hC02C, 16'hFFFE); reg_write(16'hC02E, 16'h0000);
        reg_write(16'hC030, 16'h0000); reg_write(16'hC032, 16'h0001);
        reg_write(16'hC02A, 16'h0001);
        host_write(16'hB000);
        host_write(16'hB001);
        repeat (2) @(negedge clk);
        expect_reg(16'hC02E, 16'h0001, "R8 carry into high half");
        expect_reg(16'hC02C, 16'h0002, "R8 low half after carry");
        check(bmem[8'hFF] === 16'hB000, "R7 word below boundary", bmem[8'hFF], 16'hB000);
        check(bmem[8'h00] === 16'hB001, "R8 word above boundary", bmem[8'h00], 16'hB001);

        // R4 pin toggled mid-request, one-word inbound
        reg_write(16'hC02C, 16'h0080); reg_write(16'hC02E, 16'h0000);
        reg_write(16'hC030, 16'h0080); reg_write(16'hC032, 16'h0000);
        reg_write(16'hC02A, 16'h0001);
        wait_dreq("R4 request before disable");
        reg_write(16'hC0C0, 16'h0005);
        expect_reg(16'hC0C0, 16'h0000, "R4 other value disables");
        check(dreq === 1'b0, "R4 dreq dropped by disable", dreq, 0);
        reg_write(16'hC0C0, 16'h0007);
        host_write(16'hC0DE);
        repeat (2) @(negedge clk);
        check(bmem[8'h40] === 16'hC0DE, "R7 single word inbound", bmem[8'h40], 16'hC0DE);
        expect_reg(16'hC02A, 16'h0001, "R11 done after one word");

        finish_run();
    end
endmodule